// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a countdown watchdog for a system that has to recover on its own when software stops servicing it. A prescaler divides the system clock into a slow tick; the nominal tick is 0.6 s. A 10-bit counter steps down once per tick while counting is enabled. A tick that arrives while the counter is already at zero is an expiry. After an expiry the counter reloads itself from the programmed initial value and starts another countdown without any software action.

The first expiry only warns. It sets a timeout status flag, and it raises an interrupt if software has enabled one. When a second expiry arrives while that flag is still set, the block records a second-timeout status and requests a system reset, unless the reboot-inhibit input is high. To keep the system alive, software writes the reload register and also clears the first-timeout flag by writing one to it. Together these restart the whole two-countdown sequence.

Software uses a small byte-addressed register bus with 16-bit data. Reads are combinational and have no side effects. A write takes effect at the clock edge where the write strobe is sampled high.

Top module: `wdt_dual_stage`

## Requirements
- R1: After power-on reset:
  - the control register at offset 0x08 reads 0x0800 (halted, interrupt disabled);
  - both status registers at 0x04 and 0x06 read 0;
  - the count at 0x00 and the initial value at 0x12 both read the parameter DEF_INIT;
  - the interrupt output and the reset request output are low.
- R2: While bit 11 of the control register (0x08) is 1, the count holds its value. A reload write still loads the count.
- R3: A write of any data to offset 0x00 loads the count from the initial value and restarts the prescaler. A read of 0x00 returns the count in bits 9:0, with zeros above. While running, the count falls by one every TICK_DIV clocks, first TICK_DIV clocks after the reload write.
- R4: A write to offset 0x12 sets the initial value from data bits 9:0. Data bits 15:10 are discarded, and those bits always read 0. A write whose bits 9:0 hold 0 to 3 is ignored and leaves the previous value in place.
- R5: A tick at count 0 is an expiry, and the counter reloads from the initial value. When bit 3 of status register 0x04 is clear, the expiry sets that bit. With initial value N, the first expiry after a reload write falls (N+1)·TICK_DIV clocks after it.
- R6: Writing 1 to bit 3 of 0x04 clears it. Writing 0 there, or writing any other bits, leaves it unchanged.
- R7: The interrupt output equals (bit 3 of 0x04) AND (bit 0 of 0x08, the interrupt enable). With the enable at 0, no interrupt is raised.
- R8: An expiry while bit 3 of 0x04 is set is a second expiry. It sets bit 1 of 0x06. With the inhibit input low, it also sets bit 2 of 0x06 (the boot flag) and drives the reset request high for exactly RST_CLKS clocks, starting the cycle after the expiry edge.
- R9: While the reboot-inhibit input is high, a second expiry leaves the reset request low and the boot flag unchanged, but still sets bit 1 of 0x06.
- R10: Bits 1 and 2 of 0x06 are each cleared only by writing 1 to that same bit.
- R11: Clearing bit 3 of 0x04 and then writing the reload register makes the next expiry a first expiry again, with no second timeout and no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, zero when bus_re is low |
| reboot_inhibit | input | 1 | Suppresses the reset request |
| irq_o | output | 1 | Interrupt request after the first expiry |
| sys_rst_req_o | output | 1 | Reset request pulse after the second expiry |

## Verification
A wrong count or prescaler phase shows up at the count read-back within one tick. It also moves the cycle in which the first-timeout flag appears, and the bench samples that flag one clock before and one clock after the predicted expiry edge. A wrong stage decision appears one countdown later. Symptoms include a reset request after a single expiry, a missing second-timeout flag, or a pulse that is too long or too short, and they are checked at the exact predicted edges for every initial value from 4 to 7, with and without inhibit. Ignored writes are checked by reading the affected register straight after the write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DW = 16;
    localparam int AW = 8;

    localparam logic [AW-1:0] OFS_RELOAD = 8'h00;
    localparam logic [AW-1:0] OFS_STS1   = 8'h04;
    localparam logic [AW-1:0] OFS_STS2   = 8'h06;
    localparam logic [AW-1:0] OFS_CTRL   = 8'h08;
    localparam logic [AW-1:0] OFS_TIMER  = 8'h12;

    localparam int BIT_TO1   = 3;
    localparam int BIT_TO2   = 1;
    localparam int BIT_BOOT  = 2;
    localparam int BIT_HALT  = 11;
    localparam int BIT_IRQEN = 0;

    localparam int MIN_INIT = 4;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int TICK_DIV = 60_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == LAST);
        if (!run || restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
    parameter int          CW       = 10,
    parameter logic [9:0]  DEF_INIT = 10'd50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          reload,
    input  logic [CW-1:0] init,
    output logic [CW-1:0] count,
    output logic          expire
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = tick && !reload && (st_q.cnt == '0);
        if (reload) begin
            st_d.cnt = init;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = init;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= DEF_INIT[CW-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int         CW       = 10,
    parameter logic [9:0] DEF_INIT = 10'd50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    input  logic          re,
    input  logic [CW-1:0] count,
    input  logic          expire,
    input  logic          inhibit,
    output logic [DW-1:0] rdata,
    output logic          reload_wr,
    output logic [CW-1:0] init,
    output logic          halt,
    output logic          irq,
    output logic          fire,
    output logic          sts1,
    output logic          sts2_to
);
    typedef struct packed {
        logic [CW-1:0] init;
        logic          halt;
        logic          irq_en;
        logic          to1;
        logic          to2;
        logic          boot;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic wr_sts1, wr_sts2, wr_ctrl, wr_timer;
    logic first_exp, second_exp;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        st_d       = st_q;
        reload_wr  = we && (addr == OFS_RELOAD);
        wr_sts1    = we && (addr == OFS_STS1);
        wr_sts2    = we && (addr == OFS_STS2);
        wr_ctrl    = we && (addr == OFS_CTRL);
        wr_timer   = we && (addr == OFS_TIMER);
        first_exp  = expire && !st_q.to1;
        second_exp = expire && st_q.to1;
        fire       = second_exp && !inhibit;

        if (wr_timer && (wdata[CW-1:0] >= CW'(MIN_INIT))) begin
            st_d.init = wdata[CW-1:0];
        end
        if (wr_ctrl) begin
            st_d.halt   = wdata[BIT_HALT];
            st_d.irq_en = wdata[BIT_IRQEN];
        end
        st_d.to1  = (st_q.to1 && !(wr_sts1 && wdata[BIT_TO1])) || first_exp;
        st_d.to2  = (st_q.to2 && !(wr_sts2 && wdata[BIT_TO2])) || second_exp;
        st_d.boot = (st_q.boot && !(wr_sts2 && wdata[BIT_BOOT])) || fire;
    end

    always_comb begin
        rdata = '0;
        if (re) begin
            case (addr)
                OFS_RELOAD: rdata[CW-1:0] = count;
                OFS_STS1:   rdata[BIT_TO1] = st_q.to1;
                OFS_STS2: begin
                    rdata[BIT_TO2]  = st_q.to2;
                    rdata[BIT_BOOT] = st_q.boot;
                end
                OFS_CTRL: begin
                    rdata[BIT_HALT]  = st_q.halt;
                    rdata[BIT_IRQEN] = st_q.irq_en;
                end
                OFS_TIMER:  rdata[CW-1:0] = st_q.init;
                default:    rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.init   <= DEF_INIT[CW-1:0];
            st_q.halt   <= 1'b1;
            st_q.irq_en <= 1'b0;
            st_q.to1    <= 1'b0;
            st_q.to2    <= 1'b0;
            st_q.boot   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign init    = st_q.init;
    assign halt    = st_q.halt;
    assign irq     = st_q.to1 && st_q.irq_en;
    assign sts1    = st_q.to1;
    assign sts2_to = st_q.to2;
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
    parameter int RST_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic rst_req
);
    localparam int RW = $clog2(RST_CLKS + 1);

    typedef struct packed {
        logic          act;
        logic [RW-1:0] left;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.act  = 1'b1;
            st_d.left = RW'(RST_CLKS - 1);
        end else if (st_q.act) begin
            if (st_q.left == '0) begin
                st_d.act = 1'b0;
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_req = st_q.act;
endmodule

// File: rtl/wdt_dual_stage.sv
module wdt_dual_stage
    import wdt_pkg::*;
#(
    parameter int         TICK_DIV = 60_000_000,
    parameter int         RST_CLKS = 16,
    parameter int         CW       = 10,
    parameter logic [9:0] DEF_INIT = 10'd50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    bus_addr,
    input  logic [15:0]   bus_wdata,
    input  logic          bus_we,
    input  logic          bus_re,
    output logic [15:0]   bus_rdata,
    input  logic          reboot_inhibit,
    output logic          irq_o,
    output logic          sys_rst_req_o
);
    logic          tick;
    logic          reload_wr;
    logic          halt;
    logic          expire;
    logic          fire;
    logic          sts1;
    logic          sts2_to;
    logic [CW-1:0] init;
    logic [CW-1:0] count;

    wdt_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!halt),
        .restart (reload_wr),
        .tick    (tick)
    );

    wdt_count_core #(.CW(CW), .DEF_INIT(DEF_INIT)) core_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .reload (reload_wr),
        .init   (init),
        .count  (count),
        .expire (expire)
    );

    wdt_regs #(.CW(CW), .DEF_INIT(DEF_INIT)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .we        (bus_we),
        .re        (bus_re),
        .count     (count),
        .expire    (expire),
        .inhibit   (reboot_inhibit),
        .rdata     (bus_rdata),
        .reload_wr (reload_wr),
        .init      (init),
        .halt      (halt),
        .irq       (irq_o),
        .fire      (fire),
        .sts1      (sts1),
        .sts2_to   (sts2_to)
    );

    wdt_rst_pulse #(.RST_CLKS(RST_CLKS)) pulse_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .rst_req (sys_rst_req_o)
    );
endmodule

// File: rtl/wdt_dual_stage_chk.sv
module wdt_dual_stage_chk #(
    parameter int RST_CLKS = 16,
    parameter int CW       = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          halt,
    input logic          reload_wr,
    input logic [CW-1:0] count,
    input logic [CW-1:0] init,
    input logic          sts1,
    input logic          sts2_to,
    input logic          fire,
    input logic          rst_req,
    input logic          inhibit
);
    localparam int HW = $clog2(RST_CLKS + 2);

    logic [HW-1:0] hi_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= '0;
        end else if (fire) begin
            hi_run_q <= '0;
        end else if (rst_req) begin
            hi_run_q <= hi_run_q + 1'b1;
        end else begin
            hi_run_q <= '0;
        end
    end

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(halt) && !$past(reload_wr)) |-> $stable(count));

    // R4
    init_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init >= CW'(4));

    // R8
    second_needs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts2_to) |-> $past(sts1));

    // R9
    inhibit_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> !$past(inhibit));

    // R8
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (hi_run_q < HW'(RST_CLKS)));
endmodule

bind wdt_dual_stage wdt_dual_stage_chk #(.RST_CLKS(RST_CLKS), .CW(CW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt      (halt),
    .reload_wr (reload_wr),
    .count     (count),
    .init      (init),
    .sts1      (sts1),
    .sts2_to   (sts2_to),
    .fire      (fire),
    .rst_req   (sys_rst_req_o),
    .inhibit   (reboot_inhibit)
);

// File: tb/wdt_dual_stage_tb.sv
module wdt_dual_stage_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV  = 3;
    localparam int RCLK = 4;
    localparam logic [9:0] DEFV = 10'd9;

    localparam logic [7:0] A_RLD  = 8'h00;
    localparam logic [7:0] A_ST1  = 8'h04;
    localparam logic [7:0] A_ST2  = 8'h06;
    localparam logic [7:0] A_CTL  = 8'h08;
    localparam logic [7:0] A_TMR  = 8'h12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_rdata;
    logic        reboot_inhibit = 1'b0;
    logic        irq_o;
    logic        sys_rst_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_dual_stage #(.TICK_DIV(DIV), .RST_CLKS(RCLK), .CW(10), .DEF_INIT(DEFV)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_we         (bus_we),
        .bus_re         (bus_re),
        .bus_rdata      (bus_rdata),
        .reboot_inhibit (reboot_inhibit),
        .irq_o          (irq_o),
        .sys_rst_req_o  (sys_rst_req_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a;
        bus_re   = 1'b1;
        #1;
        d        = bus_rdata;
        bus_re   = 1'b0;
    endtask

    task automatic adv(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rchk(input string tag, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] c1;
        int p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rchk("R1 ctrl", A_CTL, 16'h0800);
        rchk("R1 sts1", A_ST1, 16'h0000);
        rchk("R1 sts2", A_ST2, 16'h0000);
        rchk("R1 count", A_RLD, {6'b0, DEFV});
        rchk("R1 init", A_TMR, {6'b0, DEFV});
        chk("R1 irq", {15'b0, irq_o}, 16'h0);
        chk("R1 rst", {15'b0, sys_rst_req_o}, 16'h0);

        // R2 halted count holds
        adv(20);
        rchk("R2 halted hold", A_RLD, {6'b0, DEFV});

        // R4 writes of 0..3 ignored, upper bits discarded
        for (int v = 0; v < 4; v++) begin
            wr(A_TMR, 16'(v));
            rchk("R4 small ignored", A_TMR, {6'b0, DEFV});
        end
        wr(A_TMR, 16'hFC05);
        rchk("R4 upper bits", A_TMR, 16'h0005);

        // R2 reload still loads while halted
        wr(A_RLD, 16'h0000);
        rchk("R2 reload halted", A_RLD, 16'h0005);

        // sweep over initial value and inhibit
        for (int n = 4; n < 8; n++) begin
            for (int inh = 0; inh < 2; inh++) begin
                logic en;
                en = n[0];
                p  = (n + 1) * DIV;
                reboot_inhibit = inh[0];
                wr(A_CTL, {4'b0, 1'b1, 10'b0, en});
                wr(A_ST1, 16'h0008);
                wr(A_ST2, 16'h0006);
                wr(A_TMR, 16'(n));
                wr(A_CTL, {15'b0, en});
                wr(A_RLD, 16'h0000);
                adv(2 * DIV - 1);
                rchk("R3 before tick", A_RLD, 16'(n - 1));
                adv(1);
                rchk("R3 count after two ticks", A_RLD, 16'(n - 2));
                adv(p - 1 - 2 * DIV);
                rchk("R5 count zero", A_RLD, 16'h0000);
                rchk("R5 no early flag", A_ST1, 16'h0000);
                adv(1);
                rchk("R5 first flag", A_ST1, 16'h0008);
                rchk("R5 auto reload", A_RLD, 16'(n));
                chk("R7 irq gate", {15'b0, irq_o}, {15'b0, en});
                chk("R8 no reset after first", {15'b0, sys_rst_req_o}, 16'h0);
                adv(p - 1);
                rchk("R8 no early second", A_ST2, 16'h0000);
                adv(1);
                rchk(inh ? "R9 second status kept" : "R8 second status",
                     A_ST2, inh ? 16'h0002 : 16'h0006);
                chk(inh ? "R9 reset suppressed" : "R8 reset start",
                    {15'b0, sys_rst_req_o}, {15'b0, ~inh[0]});
                adv(RCLK - 1);
                chk(inh ? "R9 reset suppressed end" : "R8 reset held",
                    {15'b0, sys_rst_req_o}, {15'b0, ~inh[0]});
                adv(1);
                chk("R8 reset ended", {15'b0, sys_rst_req_o}, 16'h0);
                wr(A_ST2, 16'h0002);
                rchk("R10 clear bit1 only", A_ST2, inh ? 16'h0000 : 16'h0004);
                wr(A_ST2, 16'h0004);
                rchk("R10 clear boot", A_ST2, 16'h0000);
            end
        end

        // R6 / R7 / R11
        reboot_inhibit = 1'b0;
        wr(A_CTL, 16'h0800);
        wr(A_ST1, 16'h0008);
        wr(A_TMR, 16'd4);
        wr(A_CTL, 16'h0000);
        wr(A_RLD, 16'h0000);
        p = 5 * DIV;
        adv(p);
        rchk("R6 flag set", A_ST1, 16'h0008);
        chk("R7 irq disabled", {15'b0, irq_o}, 16'h0);
        wr(A_ST1, 16'h0000);
        rchk("R6 write zero no effect", A_ST1, 16'h0008);
        wr(A_ST1, 16'hFFF7);
        rchk("R6 other bits no effect", A_ST1, 16'h0008);
        wr(A_CTL, 16'h0001);
        chk("R7 irq enabled", {15'b0, irq_o}, 16'h1);
        wr(A_ST1, 16'h0008);
        rchk("R6 cleared", A_ST1, 16'h0000);
        chk("R7 irq drops", {15'b0, irq_o}, 16'h0);
        wr(A_RLD, 16'h0000);
        adv(p - 1);
        rchk("R11 no flag yet", A_ST1, 16'h0000);
        adv(1);
        rchk("R11 first again", A_ST1, 16'h0008);
        rchk("R11 no second", A_ST2, 16'h0000);
        chk("R11 no reset", {15'b0, sys_rst_req_o}, 16'h0);

        // R2 halting a running counter
        wr(A_CTL, 16'h0800);
        rd(A_RLD, c1);
        adv(20);
        rchk("R2 running halt hold", A_RLD, c1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule